// File: doc/BRIEF.md
# Eight-Input Vectored Interrupt Controller

This block gathers eight interrupt request lines, each latched on its rising edge, and hands the processor one request at a time as an 8-bit vector. Software reaches it through an 8-bit write bus with a single select bit. Select 0 is the command port and select 1 is the data port. A start word on the command port opens a short configuration sequence. The data-port writes that follow are read as the vector base, then an optional cascade word, then an optional mode word. Once that sequence is over, data-port writes load the mask register, and a command-port write of 0x20 retires the most urgent request that is in service.

The vector leaves the block as a valid/ready stream. `irq_o` is the valid, `vec_o` is the data and `ack_i` is the ready, so an acknowledge is the cycle in which both are high. While valid is high and ready is low, the offer stays up. The vector can still change during that wait if a more urgent request arrives, because an interrupt offer may be replaced before anyone takes it. Driving ready while valid is low does nothing. A read through `bus_rdata` shows the mask register when select is 1 and the in-service register when select is 0.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset, `irq_o` is low and the in-service and mask registers read 0x00. Until a full configuration sequence has ended, `irq_o` stays low and request edges are discarded. This holds for edges that arrive before the start word and for edges that arrive between its words.
- R2: A command-port write with bit 4 set is a start word. It clears the mask, request and in-service registers. Its bit 1 = 0 means a cascade word will follow and bit 0 = 1 means a mode word will follow. The data words are taken in the order base, cascade (if announced), mode (if announced). The next data write after them goes to the mask. So 0x11 takes three words, 0x13 takes base and mode, and 0x10 takes base and cascade.
- R3: Once configured, each data-port write loads the mask. A 1 in bit n blocks input n from being offered. A read with select 1 returns the mask.
- R4: The vector for input n is {base[7:3], n}, so the low three bits of the base word are dropped. A base of 0x20 gives input 0 the vector 0x20, and a base of 0x2D gives input 7 the vector 0x2F.
- R5: A rising edge on input n sets request bit n, and a line held high does not request again. A request made while its input is masked stays latched and is offered once the mask bit clears.
- R6: When several requests are eligible, the lowest-numbered one is offered first.
- R7: On an acknowledge, the offered request moves from the request register into the in-service register, and `irq_o` drops in the next cycle unless a more urgent request is eligible. A read with select 0 returns the in-service register.
- R8: A request is offered only if no input of equal or lower number is in service. A lower-numbered request still nests on top of higher-numbered ones that are in service.
- R9: Once configured, a command-port write of 0x20 clears the lowest-numbered set bit of the in-service register.
- R10: `ack_i` has no effect while `irq_o` is low. While `ack_i` is low, an offer stays up with the same vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_sel | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Mask (select 1) or in-service register (select 0) |
| irq_in | input | 8 | Request lines, rising-edge sensitive |
| irq_o | output | 1 | Vector valid / interrupt request |
| vec_o | output | 8 | Vector of the request on offer |
| ack_i | input | 1 | Vector ready / acknowledge |

## Verification
A request edge is latched at the first rising clock edge after the line goes high. `irq_o` and `vec_o` reflect that request right after that edge, because they are combinational from the registers. A register write, an end-of-interrupt command or an acknowledge shows on `bus_rdata` and `irq_o` just after the clock edge that captures it. The bench therefore drives on falling edges and makes its direct checks one falling edge later. The scoreboard monitor samples handshakes five nanoseconds after the falling edge that raised `ack_i`, which is before the rising edge that consumes it.

// File: rtl/irc_pkg.sv
package irc_pkg;
  typedef enum logic [2:0] {
    CFG_OFF,
    CFG_BASE,
    CFG_CASC,
    CFG_MODE,
    CFG_RUN
  } cfg_state_e;

  localparam logic [7:0] EOI_CODE  = 8'h20;
  localparam int         START_BIT = 4;
  localparam int         SNGL_BIT  = 1;
  localparam int         MODE_BIT  = 0;
endpackage

// File: rtl/irc_cfg_seq.sv
module irc_cfg_seq
  import irc_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_sel,
  input  logic [DW-1:0]       bus_wdata,
  output logic                cfg_ready,
  output logic                start_p,
  output logic                mask_we,
  output logic                eoi_p,
  output logic [DW-IDX_W-1:0] base_hi
);
  cfg_state_e st_q;
  logic need_casc_q, need_mode_q;

  always_comb begin
    start_p   = bus_wr && !bus_sel && bus_wdata[START_BIT];
    cfg_ready = (st_q == CFG_RUN);
    mask_we   = bus_wr && bus_sel && cfg_ready;
    eoi_p     = bus_wr && !bus_sel && cfg_ready && (bus_wdata == DW'(EOI_CODE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= CFG_OFF;
      need_casc_q <= 1'b0;
      need_mode_q <= 1'b0;
      base_hi     <= '0;
    end else if (start_p) begin
      st_q        <= CFG_BASE;
      need_casc_q <= !bus_wdata[SNGL_BIT];
      need_mode_q <= bus_wdata[MODE_BIT];
    end else if (bus_wr && bus_sel) begin
      case (st_q)
        CFG_BASE: begin
          base_hi <= bus_wdata[DW-1:IDX_W];
          if (need_casc_q)      st_q <= CFG_CASC;
          else if (need_mode_q) st_q <= CFG_MODE;
          else                  st_q <= CFG_RUN;
        end
        CFG_CASC: st_q <= need_mode_q ? CFG_MODE : CFG_RUN;
        CFG_MODE: st_q <= CFG_RUN;
        default:  st_q <= st_q;
      endcase
    end
  end
endmodule

// File: rtl/irc_req_latch.sv
module irc_req_latch #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             enable,
  input  logic             clr_all,
  input  logic [N_IRQ-1:0] take,
  output logic [N_IRQ-1:0] irr_q
);
  logic [N_IRQ-1:0] prev_q, rise;

  always_comb rise = irq_in & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_in;
      if (clr_all) irr_q <= '0;
      else         irr_q <= (irr_q & ~take) | (rise & {N_IRQ{enable}});
    end
  end
endmodule

// File: rtl/irc_first_one.sv
module irc_first_one #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |vec;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8 #(
  parameter int N_IRQ = 8,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_sel,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [N_IRQ-1:0] irq_in,
  output logic             irq_o,
  output logic [DW-1:0]    vec_o,
  input  logic             ack_i
);
  localparam int IDX_W = $clog2(N_IRQ);

  logic                cfg_ready, start_p, mask_we, eoi_p;
  logic [DW-IDX_W-1:0] base_hi;
  logic [N_IRQ-1:0]    irr_q, isr_q, mask_q, pend, take, isr_nxt;
  logic                pend_any, isr_any;
  logic [IDX_W-1:0]    pend_idx, isr_idx;

  irc_cfg_seq #(.DW(DW), .IDX_W(IDX_W)) u_cfg (
    .clk, .rst_n, .bus_wr, .bus_sel, .bus_wdata,
    .cfg_ready, .start_p, .mask_we, .eoi_p, .base_hi
  );

  irc_req_latch #(.N_IRQ(N_IRQ)) u_req (
    .clk, .rst_n, .irq_in, .enable(cfg_ready), .clr_all(start_p),
    .take, .irr_q
  );

  always_comb pend = irr_q & ~mask_q;

  irc_first_one #(.N(N_IRQ), .IDX_W(IDX_W)) u_pick_req (
    .vec(pend), .any(pend_any), .idx(pend_idx)
  );

  irc_first_one #(.N(N_IRQ), .IDX_W(IDX_W)) u_pick_isr (
    .vec(isr_q), .any(isr_any), .idx(isr_idx)
  );

  always_comb begin
    irq_o   = cfg_ready && pend_any && (!isr_any || (pend_idx < isr_idx));
    vec_o   = {base_hi, pend_idx};
    take    = (irq_o && ack_i) ? (N_IRQ'(1) << pend_idx) : '0;
    isr_nxt = isr_q | take;
    if (eoi_p && isr_any) isr_nxt[isr_idx] = 1'b0;
    bus_rdata = bus_sel ? DW'(mask_q) : DW'(isr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      isr_q  <= '0;
    end else if (start_p) begin
      mask_q <= '0;
      isr_q  <= '0;
    end else begin
      if (mask_we) mask_q <= bus_wdata[N_IRQ-1:0];
      isr_q <= isr_nxt;
    end
  end
endmodule

// File: rtl/irc_checker.sv
module irc_checker #(
  parameter int N_IRQ = 8,
  parameter int DW    = 8,
  parameter int IDX_W = $clog2(N_IRQ)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_sel,
  input logic [DW-1:0]       bus_wdata,
  input logic                irq_o,
  input logic [DW-1:0]       vec_o,
  input logic                ack_i,
  input logic                cfg_ready,
  input logic [N_IRQ-1:0]    isr_q,
  input logic [N_IRQ-1:0]    mask_q,
  input logic [DW-IDX_W-1:0] base_hi
);
  logic [N_IRQ-1:0] upto;
  logic             eoi_cmd, start_cmd;

  always_comb begin
    for (int i = 0; i < N_IRQ; i++) upto[i] = (i <= int'(vec_o[IDX_W-1:0]));
    eoi_cmd   = bus_wr && !bus_sel && (bus_wdata == DW'(8'h20));
    start_cmd = bus_wr && !bus_sel && bus_wdata[4];
  end

  AST_QUIET_UNCONFIGURED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ready |-> !irq_o); // R1
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> (isr_q == '0) && (mask_q == '0) && !cfg_ready); // R2
  AST_MASKED_NOT_OFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !mask_q[vec_o[IDX_W-1:0]]); // R3
  AST_VECTOR_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o[DW-1:IDX_W] == base_hi)); // R4
  AST_ACK_TO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ack_i && !bus_wr) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1)); // R7
  AST_NO_NEST_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((isr_q & upto) == '0)); // R8
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && cfg_ready && (isr_q != '0) && !(irq_o && ack_i))
      |=> ($countones(isr_q) == $past($countones(isr_q)) - 1)); // R9
  AST_IDLE_ACK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && ack_i && !bus_wr) |=> $stable(isr_q)); // R10
endmodule

bind irq_ctrl8 irc_checker #(.N_IRQ(N_IRQ), .DW(DW)) u_chk (.*);

// File: tb/irq_ctrl8_tb.sv
module irq_ctrl8_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_sel = 1'b0, ack_i = 1'b0;
  logic [7:0] bus_wdata = '0, irq_in = '0;
  logic [7:0] bus_rdata, vec_o;
  logic       irq_o;
  int         n_tests = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  irq_ctrl8 u_dut (.clk, .rst_n, .bus_wr, .bus_sel, .bus_wdata, .bus_rdata,
                   .irq_in, .irq_o, .vec_o, .ack_i);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic s, input logic [7:0] exp, input string tag);
    bus_sel = s; #1; chk(bus_rdata, exp, tag);
  endtask

  task automatic pulse(input logic [7:0] lines);
    @(negedge clk); irq_in = lines;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic irq_is(input logic exp, input string tag);
    #1; chk({7'd0, irq_o}, {7'd0, exp}, tag);
  endtask

  // driver: queue the expected vector, then raise ready for one cycle
  task automatic ack(input logic [7:0] v, input string tag);
    exp_q.push_back(v); tag_q.push_back(tag);
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0;
  endtask

  // monitor: sample before the consuming rising edge
  always @(negedge clk) begin
    #5;
    if (ack_i) begin
      if (exp_q.size() > 0) begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      t = tag_q.pop_front();
        n_tests++;
        if (!irq_o) begin
          n_fail++;
          $display("FAIL %s: actual no offer expected vector %h", t, e);
        end else if (vec_o !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, vec_o, e);
        end
      end else if (irq_o) begin
        n_tests++; n_fail++;
        $display("FAIL R10: actual unexpected transfer %h expected none", vec_o);
      end
    end
  end

  task automatic run_all();
    repeat (3) @(negedge clk);
    irq_is(1'b0, "R1 reset");
    rd(1'b1, 8'h00, "R1 mask reset");
    rd(1'b0, 8'h00, "R1 isr reset");
    rst_n = 1'b1;
    pulse(8'h08);
    irq_is(1'b0, "R1 unconfigured");
    wr(1'b0, 8'h11);
    pulse(8'h10);
    wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    irq_is(1'b0, "R1 early edges dropped");
    rd(1'b1, 8'h00, "R2 mask after start");
    wr(1'b1, 8'hFE);
    rd(1'b1, 8'hFE, "R3 mask readback");
    pulse(8'h02);
    irq_is(1'b0, "R3 masked input");
    pulse(8'h01);
    irq_is(1'b1, "R5 edge latched");
    ack(8'h20, "R4 base 0x20");
    irq_is(1'b0, "R7 drop after ack");
    rd(1'b0, 8'h01, "R7 isr bit0");
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h00, "R9 eoi clears");
    wr(1'b1, 8'h00);
    irq_is(1'b1, "R5 latched while masked");
    ack(8'h21, "R5 unmasked vector");
    pulse(8'h20);
    irq_is(1'b0, "R8 lower blocked");
    pulse(8'h01);
    irq_is(1'b1, "R8 higher nests");
    ack(8'h20, "R8 nested vector");
    rd(1'b0, 8'h03, "R7 two in service");
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h02, "R9 clears lowest number");
    irq_is(1'b0, "R8 still blocked");
    wr(1'b0, 8'h20);
    ack(8'h25, "R8 released after eoi");
    wr(1'b0, 8'h20);
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0;
    rd(1'b0, 8'h00, "R10 idle ack inert");
    pulse(8'h40);
    repeat (3) @(negedge clk);
    irq_is(1'b1, "R10 offer held");
    chk(vec_o, 8'h26, "R10 vector stable");
    ack(8'h26, "R10 held vector");
    wr(1'b0, 8'h20);
    pulse(8'h48);
    ack(8'h23, "R6 lowest first");
    irq_is(1'b0, "R8 input 6 waits");
    wr(1'b0, 8'h20);
    ack(8'h26, "R6 second");
    wr(1'b0, 8'h20);
    @(negedge clk); irq_in[2] = 1'b1;
    ack(8'h22, "R5 level line");
    wr(1'b0, 8'h20);
    repeat (3) @(negedge clk);
    irq_is(1'b0, "R5 held level no repeat");
    irq_in[2] = 1'b0;
    wr(1'b0, 8'h11); wr(1'b1, 8'h2D); wr(1'b1, 8'h02); wr(1'b1, 8'h01);
    rd(1'b1, 8'h00, "R2 reinit mask");
    pulse(8'h80);
    ack(8'h2F, "R4 low base bits dropped");
    wr(1'b0, 8'h13);
    rd(1'b0, 8'h00, "R2 start clears isr");
    wr(1'b1, 8'h40); wr(1'b1, 8'h01); wr(1'b1, 8'h5A);
    rd(1'b1, 8'h5A, "R2 no cascade word");
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h60); wr(1'b1, 8'h04); wr(1'b1, 8'hF0);
    rd(1'b1, 8'hF0, "R2 no mode word");
    pulse(8'h04);
    ack(8'h62, "R4 base 0x60");
    rd(1'b0, 8'h04, "R7 isr bit2");
    repeat (2) @(negedge clk);
    chk(8'(exp_q.size()), 8'h00, "R7 scoreboard drained");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule